// File: doc/BRIEF.md
# Atomic Chunked Register Multiplexer

This block sits between a narrow register bus driven by a processor and a set of peripheral registers that can each be wider than the bus data path. Every register is cut into bus-width chunks, and each chunk takes one bus address. Registers are laid out back to back from address 0. Each register's address span is padded to a multiple of `2**ALIGN_LOG` addresses.

Atomicity comes from two shadow buffers per register. The read shadow is loaded from the live register when chunk 0 is read. Every later chunk read is served from that snapshot, so a multi-chunk read sees one consistent value even if the register changes in between. The write shadow collects chunks one at a time. Only the write to the last address of the padded span hands the assembled value to the peripheral, with a one-cycle write strobe.

The register widths and access modes (read-only, write-only, read-write) are elaboration parameters. With the defaults, the bus is 8 bits wide and the alignment is 4 addresses. The layout is then:
- register 0: 24-bit, read-write, addresses 0 to 3
- register 1: 16-bit, read-only, addresses 4 to 7
- register 2: 12-bit, write-only, addresses 8 to 11

Top module: `csrChunkMux`

## Requirements
- R1: Register k occupies a contiguous block of addresses whose base is the sum of the padded spans of registers 0..k-1. Chunk c of register k sits at base+c and carries register bits [c*DATA_W +: DATA_W]. The default bases are 0, 4 and 8.
- R2: A bus read at chunk 0 of a readable register raises that register's `regRStb` bit in the same cycle. It also copies the live value into the read shadow. At most one `regRStb` bit is ever high, and only while `busRStb` is high.
- R3: A bus read at chunk c>0 returns bits [c*DATA_W +: DATA_W] of the last snapshot, even if the live value has changed since. Chunks beyond the register width read as zero.
- R4: `busRData` carries read data in the cycle after `busRStb`. In every other cycle it is zero, and it is also zero for reads of unmapped addresses. Reset clears it.
- R5: A bus write to any chunk of a writable register other than the last address of its span stores `busWData` into that chunk of the write shadow. It raises no `regWStb`, and `regWData` keeps its value.
- R6: A bus write to the last address of a writable register's span merges that chunk into the write shadow. One cycle later it drives the merged value, masked to the register width, on that register's `regWData` slice, with a single `regWStb` pulse.
- R7: The last address is the end of the padded span, not the last data chunk. The 24-bit register 0 commits on its 4th write (address 3), and the data of that write falls outside the register width.
- R8: A read-only register never raises `regWStb`. A write-only register never raises `regRStb`, and bus reads of it return zero.
- R9: Bus writes and reads at unmapped addresses change nothing. Shadows and outputs reset to zero, so a commit with no earlier staging sends zeros in the unstaged chunks.
- R10: A read and a write to the same register in the same cycle both take effect, each exactly as if it had been issued alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Bus chunk address |
| busRStb | input | 1 | Bus read strobe |
| busRData | output | DATA_W | Read data, one cycle after the strobe, otherwise zero |
| busWStb | input | 1 | Bus write strobe |
| busWData | input | DATA_W | Bus write data |
| regRData | input | NUM_REGS*MAX_W | Live register values, register k in slice k |
| regRStb | output | NUM_REGS | Per-register read side-effect strobe |
| regWData | output | NUM_REGS*MAX_W | Committed write values, register k in slice k |
| regWStb | output | NUM_REGS | Per-register write strobe |

## Verification
A read snapshot and a write commit can land on the same register in the same cycle. The case that matters most is a read strobe and a write strobe together at register 0's last address. A read of chunk 0 of register 0 combined with a staging write is also exercised. The random phase raises both strobes at once on roughly a quarter of its cycles. A bench model applies the read half and the write half of each cycle on its own terms. Every cycle is then judged on `regRStb`, `busRData`, `regWStb` and the whole `regWData` bus.

// File: rtl/csrChunkPkg.sv
package csrChunkPkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'b01,
    ACC_WO = 2'b10,
    ACC_RW = 2'b11
  } accMode_e;

  // strobes from the address decode to the shadow datapath
  typedef struct packed {
    logic rdSel;     // read of a readable register
    logic rdSnap;    // read of chunk 0: take a snapshot
    logic wrStage;   // write of a non-final chunk
    logic wrCommit;  // write of the final address
  } csrStrobes_t;

  function automatic int chunksOf(int w, int dw);
    return (w + dw - 1) / dw;
  endfunction

  function automatic int spanOf(int w, int dw, int al);
    int q;
    q = 1 << al;
    return ((chunksOf(w, dw) + q - 1) / q) * q;
  endfunction

  function automatic logic canRead(accMode_e m);
    return (m == ACC_RO) || (m == ACC_RW);
  endfunction

  function automatic logic canWrite(accMode_e m);
    return (m == ACC_WO) || (m == ACC_RW);
  endfunction

endpackage

// File: rtl/csrAddrDecode.sv
module csrAddrDecode
  import csrChunkPkg::*;
#(
  parameter int       ADDR_W    = 6,
  parameter int       DATA_W    = 8,
  parameter int       NUM_REGS  = 3,
  parameter int       ALIGN_LOG = 2,
  parameter int       IDX_W     = 2,
  parameter int       REG_W   [NUM_REGS] = '{24, 16, 12},
  parameter accMode_e REG_ACC [NUM_REGS] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRStb,
  input  logic                busWStb,
  output csrStrobes_t         strb,
  output logic [IDX_W-1:0]    selIdx,
  output logic [ADDR_W-1:0]   chunkOff,
  output logic [NUM_REGS-1:0] regRStb
);

  function automatic int baseOf(int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += spanOf(REG_W[j], DATA_W, ALIGN_LOG);
    return acc;
  endfunction

  logic [NUM_REGS-1:0] hitVec;
  logic [NUM_REGS-1:0] rdOkVec;
  logic [NUM_REGS-1:0] wrOkVec;
  logic [ADDR_W-1:0]   offVec  [NUM_REGS];
  logic [ADDR_W-1:0]   lastVec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    localparam int BASE = baseOf(i);
    localparam int SPAN = spanOf(REG_W[i], DATA_W, ALIGN_LOG);
    assign hitVec[i]  = (int'(busAddr) >= BASE) && (int'(busAddr) < BASE + SPAN);
    assign offVec[i]  = busAddr - ADDR_W'(BASE);
    assign lastVec[i] = ADDR_W'(SPAN - 1);
    assign rdOkVec[i] = canRead(REG_ACC[i]);
    assign wrOkVec[i] = canWrite(REG_ACC[i]);
  end

  logic anyHit, isLast, rdOk, wrOk;

  always_comb begin
    selIdx   = '0;
    chunkOff = '0;
    anyHit   = 1'b0;
    isLast   = 1'b0;
    rdOk     = 1'b0;
    wrOk     = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hitVec[i]) begin
        selIdx   = IDX_W'(i);
        chunkOff = offVec[i];
        anyHit   = 1'b1;
        isLast   = (offVec[i] == lastVec[i]);
        rdOk     = rdOkVec[i];
        wrOk     = wrOkVec[i];
      end
    end
  end

  always_comb begin
    strb.rdSel    = busRStb & anyHit & rdOk;
    strb.rdSnap   = busRStb & anyHit & rdOk & (chunkOff == '0);
    strb.wrStage  = busWStb & anyHit & wrOk & ~isLast;
    strb.wrCommit = busWStb & anyHit & wrOk & isLast;
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      regRStb[i] = strb.rdSnap && (selIdx == IDX_W'(i));
  end

endmodule

// File: rtl/csrShadowPath.sv
module csrShadowPath
  import csrChunkPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 3,
  parameter int MAX_W    = 32,
  parameter int IDX_W    = 2,
  parameter int REG_W [NUM_REGS] = '{24, 16, 12}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  csrStrobes_t                strb,
  input  logic [IDX_W-1:0]           selIdx,
  input  logic [ADDR_W-1:0]          chunkOff,
  input  logic [DATA_W-1:0]          busWData,
  input  logic [NUM_REGS*MAX_W-1:0]  regRData,
  output logic [DATA_W-1:0]          busRData,
  output logic [NUM_REGS*MAX_W-1:0]  regWData,
  output logic [NUM_REGS-1:0]        regWStb
);

  localparam int MAX_CHUNKS = MAX_W / DATA_W;

  logic [MAX_W-1:0] widthMask [NUM_REGS];
  logic [MAX_W-1:0] liveVal   [NUM_REGS];
  logic [MAX_W-1:0] rdShadow  [NUM_REGS];
  logic [MAX_W-1:0] wrShadow  [NUM_REGS];
  logic [MAX_W-1:0] wrOut     [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gLane
    assign widthMask[i] = (REG_W[i] >= MAX_W) ? '1 :
                          MAX_W'((64'd1 << REG_W[i]) - 64'd1);
    assign liveVal[i] = regRData[i*MAX_W +: MAX_W] & widthMask[i];
    assign regWData[i*MAX_W +: MAX_W] = wrOut[i];
  end

  function automatic logic [DATA_W-1:0] sliceOf(logic [MAX_W-1:0] v,
                                                logic [ADDR_W-1:0] c);
    return DATA_W'(v >> (int'(c) * DATA_W));
  endfunction

  logic [MAX_W-1:0] liveSel;
  logic [MAX_W-1:0] assembled;

  always_comb begin
    liveSel   = liveVal[selIdx];
    assembled = wrShadow[selIdx];
    if (int'(chunkOff) < MAX_CHUNKS)
      assembled[int'(chunkOff)*DATA_W +: DATA_W] = busWData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRData <= '0;
      regWStb  <= '0;
      for (int i = 0; i < NUM_REGS; i++) begin
        rdShadow[i] <= '0;
        wrShadow[i] <= '0;
        wrOut[i]    <= '0;
      end
    end else begin
      busRData <= '0;
      regWStb  <= '0;
      if (strb.rdSel) begin
        if (strb.rdSnap) begin
          rdShadow[selIdx] <= liveSel;
          busRData         <= sliceOf(liveSel, chunkOff);
        end else begin
          busRData <= sliceOf(rdShadow[selIdx], chunkOff);
        end
      end
      if (strb.wrStage)
        wrShadow[selIdx] <= assembled;
      if (strb.wrCommit) begin
        wrShadow[selIdx] <= assembled;
        wrOut[selIdx]    <= assembled & widthMask[selIdx];
        regWStb[selIdx]  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/csrChunkMux.sv
module csrChunkMux
  import csrChunkPkg::*;
#(
  parameter int       DATA_W    = 8,
  parameter int       ADDR_W    = 6,
  parameter int       NUM_REGS  = 3,
  parameter int       MAX_W     = 32,
  parameter int       ALIGN_LOG = 2,
  parameter int       REG_W   [NUM_REGS] = '{24, 16, 12},
  parameter accMode_e REG_ACC [NUM_REGS] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busRStb,
  output logic [DATA_W-1:0]         busRData,
  input  logic                      busWStb,
  input  logic [DATA_W-1:0]         busWData,
  input  logic [NUM_REGS*MAX_W-1:0] regRData,
  output logic [NUM_REGS-1:0]       regRStb,
  output logic [NUM_REGS*MAX_W-1:0] regWData,
  output logic [NUM_REGS-1:0]       regWStb
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  csrStrobes_t       strb;
  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] chunkOff;

  csrAddrDecode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .ALIGN_LOG(ALIGN_LOG), .IDX_W(IDX_W), .REG_W(REG_W), .REG_ACC(REG_ACC)
  ) uDecode (
    .busAddr(busAddr), .busRStb(busRStb), .busWStb(busWStb),
    .strb(strb), .selIdx(selIdx), .chunkOff(chunkOff), .regRStb(regRStb)
  );

  csrShadowPath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .MAX_W(MAX_W), .IDX_W(IDX_W), .REG_W(REG_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .selIdx(selIdx),
    .chunkOff(chunkOff), .busWData(busWData), .regRData(regRData),
    .busRData(busRData), .regWData(regWData), .regWStb(regWStb)
  );

endmodule

// File: rtl/csrChunkMuxChk.sv
module csrChunkMuxChk
  import csrChunkPkg::*;
#(
  parameter int       DATA_W   = 8,
  parameter int       NUM_REGS = 3,
  parameter accMode_e REG_ACC [NUM_REGS] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input logic                clk,
  input logic                rstN,
  input logic                busRStb,
  input logic [DATA_W-1:0]   busRData,
  input logic                busWStb,
  input logic [NUM_REGS-1:0] regRStb,
  input logic [NUM_REGS-1:0] regWStb
);

  // R4
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRStb) |-> busRData == '0);

  // R2
  rstb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regRStb));

  // R2
  rstb_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|regRStb) |-> busRStb);

  // R6
  wstb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWStb));

  // R6
  wstb_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|regWStb) |-> $past(busWStb));

  for (genvar i = 0; i < NUM_REGS; i++) begin : gAcc
    if (!canWrite(REG_ACC[i])) begin : gRo
      // R8
      ro_no_wstb_chk: assert property (@(posedge clk) disable iff (!rstN)
        !regWStb[i]);
    end
    if (!canRead(REG_ACC[i])) begin : gWo
      // R8
      wo_no_rstb_chk: assert property (@(posedge clk) disable iff (!rstN)
        !regRStb[i]);
    end
  end

endmodule

bind csrChunkMux csrChunkMuxChk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REG_ACC(REG_ACC)
) chk (
  .clk(clk), .rstN(rstN), .busRStb(busRStb), .busRData(busRData),
  .busWStb(busWStb), .regRStb(regRStb), .regWStb(regWStb)
);

// File: tb/csrChunkMux_test.sv
`timescale 1ns/1ps
module csrChunkMux_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busRStb = 1'b0;
  logic [7:0]  busRData;
  logic        busWStb = 1'b0;
  logic [7:0]  busWData = '0;
  logic [95:0] regRData = '0;
  logic [2:0]  regRStb;
  logic [95:0] regWData;
  logic [2:0]  regWStb;

  always #2 clk = ~clk;

  csrChunkMux uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRStb(busRStb),
    .busRData(busRData), .busWStb(busWStb), .busWData(busWData),
    .regRData(regRData), .regRStb(regRStb), .regWData(regWData),
    .regWStb(regWStb)
  );

  int applied = 0;
  int miscompares = 0;

  // layout from R1 and R7: bases 0/4/8, span 4, widths 24/16/12
  int  rBase [3] = '{0, 4, 8};
  int  rWid  [3] = '{24, 16, 12};
  bit  rRd   [3] = '{1'b1, 1'b1, 1'b0};
  bit  rWr   [3] = '{1'b1, 1'b0, 1'b1};

  logic [31:0] live  [3];
  logic [31:0] snap  [3];
  logic [31:0] stage [3];
  logic [31:0] wOut  [3];

  function automatic logic [31:0] maskOf(int i);
    return (32'd1 << rWid[i]) - 32'd1;
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [95:0] act, logic [95:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int a, bit rs, bit ws, logic [7:0] wd);
    int hit = -1;
    int c = 0;
    logic [2:0]  eRStb = '0;
    logic [7:0]  eRData = '0;
    logic [2:0]  eWStb = '0;
    logic [31:0] asm;
    string rTag, wTag;
    for (int i = 0; i < 3; i++)
      if (a >= rBase[i] && a < rBase[i] + 4) begin hit = i; c = a - rBase[i]; end
    rTag = (hit < 0) ? "R4" : (!rRd[hit] ? "R8" : (c == 0 ? "R2" : "R3"));
    wTag = (hit < 0) ? "R9" : (!rWr[hit] ? "R8" : (c == 3 ? "R6" : "R5"));
    if (rs && ws) wTag = {wTag, " R10"};
    if (hit >= 0 && rs && rRd[hit]) begin
      if (c == 0) begin eRStb[hit] = 1'b1; snap[hit] = live[hit] & maskOf(hit); end
      eRData = 8'(snap[hit] >> (8 * c));
    end
    if (hit >= 0 && ws && rWr[hit]) begin
      asm = stage[hit];
      asm[8*c +: 8] = wd;
      stage[hit] = asm;
      if (c == 3) begin eWStb[hit] = 1'b1; wOut[hit] = asm & maskOf(hit); end
    end
    @(negedge clk);
    busAddr = 6'(a); busRStb = rs; busWStb = ws; busWData = wd;
    regRData = {live[2], live[1], live[0]};
    #1;
    check(regRStb == eRStb, rTag, "regRStb", 96'(regRStb), 96'(eRStb));
    @(posedge clk);
    #1;
    check(busRData == eRData, rTag, "busRData", 96'(busRData), 96'(eRData));
    check(regWStb == eWStb, wTag, "regWStb", 96'(regWStb), 96'(eWStb));
    check(regWData == {wOut[2], wOut[1], wOut[0]}, wTag, "regWData",
          regWData, {wOut[2], wOut[1], wOut[0]});
    busRStb = 1'b0; busWStb = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 3; i++) begin
      live[i] = '0; snap[i] = '0; stage[i] = '0; wOut[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R4 R9 reset state
    check(busRData == 8'h0, "R4", "reset busRData", 96'(busRData), 96'h0);
    check(regWData == '0 && regWStb == '0, "R9", "reset write side",
          regWData, 96'h0);
    check(regRStb == '0, "R2", "reset regRStb", 96'(regRStb), 96'h0);
    rstN = 1'b1;

    // R9: commit on register 2 with nothing staged: padding chunk data dropped
    cyc(11, 0, 1, 8'hA5);
    check(regWData[95:64] == 32'h0, "R9", "unstaged commit", regWData[95:64], 96'h0);

    // R3: snapshot holds after the live value moves
    live[0] = 32'h00ABCDEF;
    cyc(0, 1, 0, 8'h00);
    live[0] = 32'h00123456;
    cyc(1, 1, 0, 8'h00);
    check(busRData == 8'hCD, "R3", "old snapshot chunk1", 96'(busRData), 96'hCD);
    cyc(2, 1, 0, 8'h00);
    cyc(3, 1, 0, 8'h00);

    // R5 R7: staged writes do not reach register 0 until address 3
    cyc(0, 0, 1, 8'h11);
    cyc(1, 0, 1, 8'h22);
    cyc(2, 0, 1, 8'h33);
    check(regWData[31:0] == 32'h0, "R5", "no commit before last", regWData[31:0], 96'h0);
    cyc(3, 0, 1, 8'h44);
    check(regWData[31:0] == 32'h00332211, "R7", "commit on 4th write",
          regWData[31:0], 96'h00332211);

    // R1: register 1 chunks at addresses 4 and 5
    live[1] = 32'h0000BEEF;
    cyc(4, 1, 0, 8'h00);
    check(busRData == 8'hEF, "R1", "reg1 chunk0 at addr 4", 96'(busRData), 96'hEF);
    cyc(5, 1, 0, 8'h00);
    check(busRData == 8'hBE, "R1", "reg1 chunk1 at addr 5", 96'(busRData), 96'hBE);

    // R8: write to read-only, read of write-only
    cyc(7, 0, 1, 8'h77);
    cyc(8, 1, 0, 8'h00);
    // R9: unmapped write and read
    cyc(20, 1, 1, 8'h5A);
    cyc(63, 0, 1, 8'hC3);

    // R10: read and write together
    live[0] = 32'h00FEDCBA;
    cyc(0, 1, 1, 8'h9A);
    cyc(3, 1, 1, 8'h01);
    cyc(1, 1, 1, 8'h02);

    for (int n = 0; n < 1500; n++) begin
      int a;
      bit rs, ws;
      if (($urandom % 8) == 0) a = $urandom_range(0, 63);
      else a = $urandom_range(0, 11);
      rs = ($urandom % 2) == 1;
      ws = ($urandom % 2) == 1;
      if (($urandom % 4) == 0) begin
        int k = $urandom_range(0, 2);
        live[k] = $urandom & maskOf(k);
      end
      cyc(a, rs, ws, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule